// File: doc/BRIEF.md
# Dual-Clock Frame Readout Buffer

This block parks one frame of byte results between a processing pipeline and a processor whose clock has no relation to the pipeline's. The pipeline stores bytes through a plain synchronous write port on its own clock. The processor side only reads. It presents an address, and optionally a strobe, that are asynchronous to everything in the block. A free-running read-side clock samples them, and a synchronous-read memory port delivers the byte.

When the processor has no strobe, the block finds reads by itself. It passes the address through a two-flop synchronizer and launches a read once the settled address differs from the one last read and has held for two consecutive samples. When a strobe is wired, its synchronized rising edge launches the read instead. A ready flag tells the processor that the last location of the frame has been written. The flag crosses clock domains as a toggle and drops when the processor reads that last location.

Top module: `fb_frame_buf`

## Requirements
- R1: The store holds DEPTH=1024 bytes at addresses 0..1023 (10 address bits), and every written byte can be read back from its own address.
- R2: A byte is stored only on a wclk rising edge with wr_en high; with wr_en low, wr_addr and wr_data change nothing in the store.
- R3: rd_data holds its value between launched reads; a write to the address currently shown does not alter rd_data until a new read is launched.
- R4: In address-change mode (TRIG_MODE=TRIG_ADDR, the default), a read is launched when the synchronized address differs from the last read address and is equal in two consecutive samples; rd_data shows the new byte within 5 rclk cycles, and an address that lasts for only one rclk sample launches no read.
- R5: The first read-clock cycle after the read-side reset is released always launches a read, so rd_data shows the byte at address 0 within 5 rclk cycles when rd_addr is 0.
- R6: In strobe mode (TRIG_MODE=TRIG_STROBE), address changes alone launch nothing; a rising edge of the synchronized rd_stb while the address is stable launches a read of that address.
- R7: A write to address 1023 sets frame_ready within 6 rclk cycles; writes to other addresses do not set it.
- R8: frame_ready falls only when a read of address 1023 is launched on that instance.
- R9: While rrst_n is low, rd_data is 0 and frame_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Pipeline (write) clock |
| wrst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 10 | Write address |
| wr_data | input | 8 | Write byte |
| rclk | input | 1 | Free-running read-side clock |
| rrst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_addr | input | 10 | Processor address, asynchronous |
| rd_stb | input | 1 | Processor read strobe, asynchronous, tie low if absent |
| rd_data | output | 8 | Byte of the last launched read, held |
| frame_ready | output | 1 | Last frame location written, not yet read |

## Verification
The bench holds an address and rewrites the byte behind it. A design that re-reads continuously instead of on a launched read would show the new byte. It drives a one-sample address glitch. Logic that trusts a single synchronized sample would launch a read of the glitch address and leave the wrong byte on rd_data. In strobe mode it moves the address without a strobe, which a design that ignores the mode would follow. It resets the read side with the address parked at 0 after changing that byte. Without the forced first read, the output would keep its reset value of 0. It then reads address 1023 on one instance only and checks that the other instance keeps its ready flag.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;
  typedef enum logic {
    TRIG_ADDR   = 1'b0,
    TRIG_STROBE = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/fb_rst_sync.sv
`timescale 1ns/1ps
module fb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/fb_dpram.sv
`timescale 1ns/1ps
module fb_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rsrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  // write port: whole-byte update, so a colliding read sees old or new byte
  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  // read port: output register only moves on a launched read
  always_ff @(posedge rclk or negedge rsrst_n) begin
    if (!rsrst_n) rdata <= '0;
    else if (re)  rdata <= store_q[raddr];
  end
endmodule

// File: rtl/fb_rd_trigger.sv
`timescale 1ns/1ps
module fb_rd_trigger
  import fb_pkg::*;
#(
  parameter int         AW   = 10,
  parameter trig_mode_e MODE = TRIG_ADDR
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          stb_in,
  output logic          trig,
  output logic [AW-1:0] trig_addr,
  output logic          primed
);
  localparam bit ADDR_MODE = (MODE == TRIG_ADDR);

  logic [AW-1:0] a_s1_q, a_s2_q, a_s3_q, last_q, last_n;
  logic [2:0]    stb_q;
  logic          primed_q;
  logic          settled, moved, stb_rise, hit;

  always_comb begin
    settled  = (a_s2_q == a_s3_q);
    moved    = (a_s2_q != last_q);
    stb_rise = stb_q[1] & ~stb_q[2];
    hit      = settled & (stb_rise | (ADDR_MODE & moved));
    trig     = hit | ~primed_q;
    last_n   = trig ? a_s2_q : last_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      a_s1_q   <= '0;
      a_s2_q   <= '0;
      a_s3_q   <= '0;
      last_q   <= '0;
      stb_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      a_s1_q   <= addr_in;
      a_s2_q   <= a_s1_q;
      a_s3_q   <= a_s2_q;
      last_q   <= last_n;
      stb_q    <= {stb_q[1:0], stb_in};
      primed_q <= 1'b1;
    end
  end

  assign trig_addr = a_s2_q;
  assign primed    = primed_q;
endmodule

// File: rtl/fb_ready_xfer.sv
`timescale 1ns/1ps
module fb_ready_xfer (
  input  logic wclk,
  input  logic wsrst_n,
  input  logic last_wr,
  input  logic rclk,
  input  logic rsrst_n,
  input  logic last_rd,
  output logic ready
);
  logic       wtog_q, wtog_n;
  logic [2:0] rtog_q;
  logic       ready_q, ready_n, set_pulse;

  always_comb wtog_n = wtog_q ^ last_wr;

  always_ff @(posedge wclk or negedge wsrst_n) begin
    if (!wsrst_n) wtog_q <= 1'b0;
    else          wtog_q <= wtog_n;
  end

  always_comb begin
    set_pulse = rtog_q[1] ^ rtog_q[2];
    ready_n   = set_pulse | (ready_q & ~last_rd);
  end

  always_ff @(posedge rclk or negedge rsrst_n) begin
    if (!rsrst_n) begin
      rtog_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      rtog_q  <= {rtog_q[1:0], wtog_q};
      ready_q <= ready_n;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/fb_frame_buf.sv
`timescale 1ns/1ps
module fb_frame_buf
  import fb_pkg::*;
#(
  parameter int         DW        = 8,
  parameter int         DEPTH     = 1024,
  parameter trig_mode_e TRIG_MODE = TRIG_ADDR,
  localparam int        AW        = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_data,
  output logic          frame_ready
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          wsrst_n, rsrst_n;
  logic          trig, primed;
  logic [AW-1:0] trig_addr;
  logic          last_wr, last_rd;

  fb_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .srst_n(wsrst_n));
  fb_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .srst_n(rsrst_n));

  fb_rd_trigger #(.AW(AW), .MODE(TRIG_MODE)) u_trig (
    .clk(rclk), .srst_n(rsrst_n), .addr_in(rd_addr), .stb_in(rd_stb),
    .trig(trig), .trig_addr(trig_addr), .primed(primed)
  );

  fb_dpram #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rclk), .rsrst_n(rsrst_n), .re(trig), .raddr(trig_addr),
    .rdata(rd_data)
  );

  always_comb begin
    last_wr = wr_en & (wr_addr == LAST_ADDR);
    last_rd = trig & (trig_addr == LAST_ADDR);
  end

  fb_ready_xfer u_rdy (
    .wclk(wclk), .wsrst_n(wsrst_n), .last_wr(last_wr),
    .rclk(rclk), .rsrst_n(rsrst_n), .last_rd(last_rd),
    .ready(frame_ready)
  );
endmodule

// File: rtl/fb_frame_buf_chk.sv
`timescale 1ns/1ps
module fb_frame_buf_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          wclk,
  input logic          wsrst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wtog,
  input logic          rclk,
  input logic          rsrst_n,
  input logic          trig,
  input logic [AW-1:0] trig_addr,
  input logic          primed,
  input logic [DW-1:0] rd_data,
  input logic          frame_ready
);
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

  // R3: output register moves only after a launched read
  p_hold_r3: assert property (@(posedge rclk) disable iff (!rsrst_n)
    !trig |=> $stable(rd_data));

  // R5: the unprimed cycle is followed by a primed one, never left unprimed
  p_primed_r5: assert property (@(posedge rclk) disable iff (!rsrst_n)
    !primed |=> primed);

  // R8: ready only drops after a launched read of the last address
  p_clear_r8: assert property (@(posedge rclk) disable iff (!rsrst_n)
    $fell(frame_ready) |-> ($past(trig) && $past(trig_addr) == LAST_ADDR));

  // R7: a write to the last address flips the crossing toggle
  p_toggle_r7: assert property (@(posedge wclk) disable iff (!wsrst_n)
    (wr_en && wr_addr == LAST_ADDR) |=> (wtog != $past(wtog)));
endmodule

bind fb_frame_buf fb_frame_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .wsrst_n(wsrst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wtog(u_rdy.wtog_q), .rclk(rclk), .rsrst_n(rsrst_n), .trig(trig),
  .trig_addr(trig_addr), .primed(primed), .rd_data(rd_data),
  .frame_ready(frame_ready)
);

// File: tb/sim_fb_frame_buf.sv
`timescale 1ns/1ps
module sim_fb_frame_buf;
  localparam int NV = 8;
  // {addr[17:8], data[7:0]}
  localparam logic [17:0] VEC [NV] = '{
    {10'd0,    8'hA5}, {10'd1,    8'h3C}, {10'd2,   8'hFF}, {10'd511, 8'h00},
    {10'd512,  8'h81}, {10'd1022, 8'h5A}, {10'd100, 8'h7E}, {10'd3,   8'hC3}
  };

  logic       wclk = 1'b0, rclk = 1'b0;
  logic       wrst_n = 1'b0, rrst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] rd_addr0 = '0, rd_addr1 = '0;
  logic       rd_stb1 = 1'b0;
  logic [7:0] rd_data0, rd_data1;
  logic       ready0, ready1;
  int         total = 0, bad = 0;

  always #5 rclk = ~rclk;
  always #7 wclk = ~wclk;

  fb_frame_buf u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_addr(rd_addr0),
    .rd_stb(1'b0), .rd_data(rd_data0), .frame_ready(ready0)
  );

  fb_frame_buf #(.TRIG_MODE(fb_pkg::TRIG_STROBE)) u1 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rclk(rclk), .rrst_n(rrst_n), .rd_addr(rd_addr1),
    .rd_stb(rd_stb1), .rd_data(rd_data1), .frame_ready(ready1)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rcyc(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd0(input logic [9:0] a);
    @(negedge rclk);
    rd_addr0 = a;
    rcyc(5);
  endtask

  task automatic rd1(input logic [9:0] a);
    @(negedge rclk);
    rd_addr1 = a;
    rcyc(4);
    rd_stb1 = 1'b1;
    rcyc(3);
    rd_stb1 = 1'b0;
    rcyc(3);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rcyc(3);
    // R9: reset state
    chk("R9 rd_data in reset", rd_data0, 8'h00);
    chk("R9 ready in reset", {7'd0, ready0}, 8'h00);
    wrst_n = 1'b1;
    for (int i = 0; i < NV; i++) wr(VEC[i][17:8], VEC[i][7:0]);
    @(negedge rclk);
    rrst_n = 1'b1;
    rcyc(6);
    // R7: no ready flag for other addresses
    chk("R7 ready without last write", {7'd0, ready0}, 8'h00);
    // R1 R4: address-change reads across the table
    for (int i = 0; i < NV; i++) begin
      rd0(VEC[i][17:8]);
      chk("R1 R4 table read", rd_data0, VEC[i][7:0]);
    end
    // R6: strobe-mode reads across the table
    for (int i = 0; i < NV; i++) begin
      rd1(VEC[i][17:8]);
      chk("R6 strobe read", rd_data1, VEC[i][7:0]);
    end
    // R4: one-sample glitch launches nothing (u0 parked at address 3)
    @(negedge rclk);
    rd_addr0 = 10'd100;
    @(negedge rclk);
    rd_addr0 = 10'd3;
    rcyc(6);
    chk("R4 glitch ignored", rd_data0, 8'hC3);
    // R3: rewrite the shown address, output holds
    wr(10'd3, 8'h11);
    rcyc(6);
    chk("R3 hold after rewrite", rd_data0, 8'hC3);
    rd0(10'd1);
    rd0(10'd3);
    chk("R3 new byte after reread", rd_data0, 8'h11);
    // R2: disabled write leaves the store alone
    @(negedge wclk);
    wr_addr = 10'd1; wr_data = 8'h99;
    repeat (3) @(negedge wclk);
    rd0(10'd2);
    rd0(10'd1);
    chk("R2 no write without enable", rd_data0, 8'h3C);
    // R6: address move without strobe changes nothing
    @(negedge rclk);
    rd_addr1 = 10'd512;
    rcyc(8);
    chk("R6 no strobe no read", rd_data1, 8'hC3);
    rd_stb1 = 1'b1;
    rcyc(3);
    rd_stb1 = 1'b0;
    rcyc(3);
    chk("R6 strobe launches read", rd_data1, 8'h81);
    // R7: last address sets ready
    wr(10'd1023, 8'hE7);
    rcyc(6);
    chk("R7 ready u0", {7'd0, ready0}, 8'h01);
    chk("R7 ready u1", {7'd0, ready1}, 8'h01);
    // R8: reading last address clears only that instance
    rd0(10'd1023);
    chk("R8 last byte", rd_data0, 8'hE7);
    chk("R8 ready cleared", {7'd0, ready0}, 8'h00);
    chk("R8 other ready kept", {7'd0, ready1}, 8'h01);
    // R5: forced first read after read-side reset
    rd0(10'd0);
    chk("R5 addr0 before", rd_data0, 8'hA5);
    wr(10'd0, 8'h4B);
    rcyc(4);
    chk("R5 held before reset", rd_data0, 8'hA5);
    @(negedge rclk);
    rrst_n = 1'b0;
    rcyc(2);
    chk("R9 rd_data reset again", rd_data0, 8'h00);
    rrst_n = 1'b1;
    rcyc(5);
    chk("R5 first read after reset", rd_data0, 8'h4B);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule